// File: doc/BRIEF.md
# SCSI Controller Register and Command Front-End

This block is the byte-wide register file that sits between a host bus and a simple SCSI initiator. Each of its sixteen addresses has a separate read-side register and write-side register, so the value written to an address is not, in general, what a read of that address returns. A write of an opcode to the command register updates the read-side status, interrupt, sequence-step and FIFO-flags registers in a fixed way for each opcode. A single level interrupt output follows the interrupt-pending bit of the status register. Reading the interrupt register returns its value and clears it in the same access.

The SCSI bus phases, the target devices and the DMA engine lie outside this block. A selection command only sends out a one-cycle request strobe that carries the target ID. The outcome of the selection comes back on two event inputs: one for a target that answered and one for a target that is absent. A small data FIFO holds bytes that are written to and read from the FIFO address.

Top module: `scsi_regfront`

## Requirements
- R1: The reset values are as follows. Every read-side and write-side register is 0x00, except that read address 0xE (high transfer count, chip variant) returns 0x04 and read address 0x8 (configuration 1) returns 0x07. The interrupt output is low.
- R2: Read data is registered and appears one cycle after `rd_en`. The `irq` output is high exactly when bit 7 (0x80) of the status register at read address 0x4 is set. Commands and events set that bit, and a read of the interrupt register clears it.
- R3: A read of the interrupt register (address 0x5) returns its current value. The same read then clears that register, clears status bits 7 and 4 (interrupt pending and terminal count, mask 0x90), loads 0x04 (command done) into the sequence-step register (address 0x6), and lowers `irq`.
- R4: Opcode 0x01 (flush) empties the FIFO, sets the interrupt register to 0x08 (function complete), zeroes sequence step and FIFO flags (address 0x7), and raises the interrupt.
- R5: Opcode 0x02 (chip reset) returns every register and the FIFO to the R1 values and lowers `irq`.
- R6: Opcode 0x03 (bus reset) loads 0x80 into the interrupt register. It raises the interrupt only when bit 6 (0x40) of the written configuration-1 register (address 0x8) is clear.
- R7: Opcode 0x11 (initiator command-complete) sets the interrupt register to 0x08, ORs 0x07 (message-in phase) into status, and raises the interrupt.
- R8: Opcode 0x12 (message accepted) sets the interrupt register to 0x20 (disconnect), zeroes sequence step and FIFO flags, and raises the interrupt. Opcode 0x44 (enable selection) zeroes the interrupt register and leaves `irq` unchanged.
- R9: Opcodes 0x42 and 0x43 (select with ATN, and select with ATN and stop) pulse `sel_req` for one cycle. `sel_id` carries bits 2:0 of the written bus-ID register (address 0x4). `sel_stop` is 0 for 0x42 and 1 for 0x43, and it holds that value until the next select.
- R10: When `tgt_absent` pulses, status becomes 0x80, the interrupt register becomes 0x20, and sequence step becomes 0x00. When `tgt_ok` pulses, status becomes 0x90, or 0x92 if `sel_stop` is set, the interrupt register becomes 0x18, and sequence step becomes 0x04. A command written in the same cycle takes effect after the event.
- R11: Bit 7 of a written command byte copies the written transfer-count registers (addresses 0x0 and 0x1) into their read side. Bits 6:0 select the opcode. Without bit 7, the read side of the transfer count is left unchanged.
- R12: An unrecognised opcode changes no register except the read-side command register (address 0x3), which stores the byte as written. Opcode 0x1A (set ATN) and opcode 0x00 behave the same way.
- R13: A write to addresses 0xC to 0xF changes nothing and pulses `wr_err` for one cycle.
- R14: A write to address 0x2 pushes a byte into the FIFO, and is ignored when the FIFO is full. A read of address 0x2 pops the oldest byte, or returns 0x00 when the FIFO is empty. The FIFO-flags register tracks the fill level after every push and every pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt (status bit 7) |
| wr_err | output | 1 | One-cycle pulse on a write to an invalid address |
| sel_req | output | 1 | One-cycle selection request |
| sel_id | output | 3 | Target ID for the selection |
| sel_stop | output | 1 | Selection stops after the command phase |
| tgt_ok | input | 1 | Event: the selected target responded |
| tgt_absent | input | 1 | Event: the selected target is absent |

## Verification
Every result is due one clock edge after its stimulus: read data, the interrupt level, the selection strobe and the error pulse are all registered. The bench drives each stimulus at a falling edge and checks the outputs at the next falling edge. A read queues its expected byte in the scoreboard, and the monitor compares it at the falling edge that follows the rising edge that captured the read. Single-cycle pulses are also checked one cycle later, to confirm that they have dropped.

// File: rtl/scsi_regfront.sv
module scsi_regfront #(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       wr_err,
  output logic       sel_req,
  output logic [2:0] sel_id,
  output logic       sel_stop,
  input  logic       tgt_ok,
  input  logic       tgt_absent
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int CW = PW + 1;
  localparam logic [3:0] A_TCLO = 4'h0, A_TCMID = 4'h1, A_FIFO = 4'h2, A_CMD = 4'h3,
                         A_STAT = 4'h4, A_INTR = 4'h5, A_SEQ = 4'h6, A_FLAGS = 4'h7,
                         A_CFG1 = 4'h8, A_TCHI = 4'hE;

  logic [7:0] rreg [16];
  logic [7:0] wreg [16];
  logic [7:0] fifo_q [FIFO_DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count, count_n;

  logic cmd_wr;
  logic [6:0] op;
  logic push, pop, flush;

  assign cmd_wr  = wr_en && addr == A_CMD;
  assign op      = wdata[6:0];
  assign push    = wr_en && addr == A_FIFO && count < CW'(FIFO_DEPTH);
  assign pop     = rd_en && addr == A_FIFO && count != '0;
  assign flush   = cmd_wr && (op == 7'h01 || op == 7'h02);
  assign count_n = count + CW'(push) - CW'(pop);
  assign irq     = rreg[A_STAT][7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        fifo_q[wptr] <= wdata;
        wptr <= wptr + 1'b1;
      end
      if (pop) rptr <= rptr + 1'b1;
      count <= count_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        rreg[i] <= 8'h00;
        wreg[i] <= 8'h00;
      end
      rreg[A_TCHI] <= 8'h04;
      rreg[A_CFG1] <= 8'h07;
      rdata    <= 8'h00;
      wr_err   <= 1'b0;
      sel_req  <= 1'b0;
      sel_id   <= 3'd0;
      sel_stop <= 1'b0;
    end else begin
      sel_req <= 1'b0;
      wr_err  <= 1'b0;

      if (tgt_absent) begin
        rreg[A_STAT] <= 8'h80;
        rreg[A_INTR] <= 8'h20;
        rreg[A_SEQ]  <= 8'h00;
      end else if (tgt_ok) begin
        rreg[A_STAT] <= sel_stop ? 8'h92 : 8'h90;
        rreg[A_INTR] <= 8'h18;
        rreg[A_SEQ]  <= 8'h04;
      end

      if (rd_en) begin
        if (addr == A_FIFO) rdata <= pop ? fifo_q[rptr] : 8'h00;
        else                rdata <= rreg[addr];
        if (addr == A_INTR) begin
          rreg[A_INTR] <= 8'h00;
          rreg[A_STAT] <= rreg[A_STAT] & 8'h6F;
          rreg[A_SEQ]  <= 8'h04;
        end
      end

      if (push || pop) rreg[A_FLAGS] <= 8'(count_n);

      if (wr_en) begin
        if (addr >= 4'hC) wr_err <= 1'b1;
        else if (addr != A_FIFO) wreg[addr] <= wdata;
        if (addr >= A_CFG1 && addr < 4'hC) rreg[addr] <= wdata;
      end

      if (cmd_wr) begin
        rreg[A_CMD] <= wdata;
        if (wdata[7]) begin
          rreg[A_TCLO]  <= wreg[A_TCLO];
          rreg[A_TCMID] <= wreg[A_TCMID];
        end
        case (op)
          7'h01: begin
            rreg[A_INTR]  <= 8'h08;
            rreg[A_SEQ]   <= 8'h00;
            rreg[A_FLAGS] <= 8'h00;
            rreg[A_STAT]  <= rreg[A_STAT] | 8'h80;
          end
          7'h02: begin
            for (int i = 0; i < 16; i++) begin
              rreg[i] <= 8'h00;
              wreg[i] <= 8'h00;
            end
            rreg[A_TCHI] <= 8'h04;
            rreg[A_CFG1] <= 8'h07;
            sel_stop <= 1'b0;
            sel_id   <= 3'd0;
          end
          7'h03: begin
            rreg[A_INTR] <= 8'h80;
            if (!wreg[A_CFG1][6]) rreg[A_STAT] <= rreg[A_STAT] | 8'h80;
          end
          7'h11: begin
            rreg[A_INTR] <= 8'h08;
            rreg[A_STAT] <= rreg[A_STAT] | 8'h87;
          end
          7'h12: begin
            rreg[A_INTR]  <= 8'h20;
            rreg[A_SEQ]   <= 8'h00;
            rreg[A_FLAGS] <= 8'h00;
            rreg[A_STAT]  <= rreg[A_STAT] | 8'h80;
          end
          7'h42, 7'h43: begin
            sel_req  <= 1'b1;
            sel_id   <= wreg[A_STAT][2:0];
            sel_stop <= op[0];
          end
          7'h44: rreg[A_INTR] <= 8'h00;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scsi_regfront_chk.sv
module scsi_regfront_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic       irq,
  input logic       wr_err,
  input logic       sel_req,
  input logic       tgt_ok,
  input logic       tgt_absent
);
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en && addr >= 4'hC)); // R13

  AST_SEL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req |-> $past(wr_en && addr == 4'h3 && (wdata[6:0] == 7'h42 || wdata[6:0] == 7'h43))); // R9

  AST_SEL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req |=> !sel_req || $past(wr_en && addr == 4'h3 && (wdata[6:0] == 7'h42 || wdata[6:0] == 7'h43))); // R9

  AST_INTR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 4'h5 && !tgt_ok && !tgt_absent) |=> !irq); // R3

  AST_CHIP_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h3 && wdata[6:0] == 7'h02) |=> !irq); // R5

  AST_FLUSH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h3 && wdata[6:0] == 7'h01) |=> irq); // R4

  AST_ICCS_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h3 && wdata[6:0] == 7'h11) |=> irq); // R7
endmodule

bind scsi_regfront scsi_regfront_chk u_chk (.*);

// File: tb/sim_scsi_regfront.sv
module sim_scsi_regfront;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, wr_err, sel_req, sel_stop;
  logic [2:0] sel_id;
  logic tgt_ok = 1'b0, tgt_absent = 1'b0;

  int tests = 0, fails = 0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  scsi_regfront u0 (.*);

  always @(posedge clk) rd_d <= rd_en;

  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string t);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", t, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ok_evt();
    @(negedge clk);
    tgt_ok = 1'b1;
    @(negedge clk);
    tgt_ok = 1'b0;
  endtask

  task automatic absent_evt();
    @(negedge clk);
    tgt_absent = 1'b1;
    @(negedge clk);
    tgt_absent = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(irq, 1'b0, "R1 irq after reset");
    rd(4'h4, 8'h00, "R1 status");
    rd(4'h5, 8'h00, "R1 intr");
    rd(4'hE, 8'h04, "R1 tc high variant");
    rd(4'h8, 8'h07, "R1 cfg1");

    wr(4'h2, 8'hA5);
    wr(4'h2, 8'h3C);
    rd(4'h7, 8'h02, "R14 flags after two pushes");
    rd(4'h2, 8'hA5, "R14 fifo order");
    rd(4'h7, 8'h01, "R14 flags after pop");

    wr(4'h3, 8'h01);
    chk(irq, 1'b1, "R4 flush raises irq");
    rd(4'h7, 8'h00, "R4 flags zeroed");
    rd(4'h4, 8'h80, "R2 status bit7 with irq");
    rd(4'h5, 8'h08, "R3 intr value returned");
    chk(irq, 1'b0, "R3 irq lowered by intr read");
    rd(4'h4, 8'h00, "R3 status cleared");
    rd(4'h6, 8'h04, "R3 seq command done");
    rd(4'h2, 8'h00, "R4 fifo emptied");

    wr(4'h3, 8'h11);
    chk(irq, 1'b1, "R7 iccs raises irq");
    rd(4'h4, 8'h87, "R7 status message-in");
    rd(4'h5, 8'h08, "R7 intr function complete");

    wr(4'h3, 8'h03);
    chk(irq, 1'b1, "R6 bus reset reported");
    rd(4'h5, 8'h80, "R6 intr reset code");
    wr(4'h8, 8'h40);
    wr(4'h3, 8'h03);
    chk(irq, 1'b0, "R6 bus reset masked");
    rd(4'h5, 8'h80, "R6 intr code when masked");

    wr(4'h3, 8'h12);
    chk(irq, 1'b1, "R8 msg accepted raises irq");
    rd(4'h6, 8'h00, "R8 seq zeroed");
    wr(4'h3, 8'h44);
    chk(irq, 1'b1, "R8 enable selection keeps irq");
    rd(4'h5, 8'h00, "R8 enable selection zeroes intr");

    wr(4'h3, 8'h12);
    wr(4'h3, 8'h55);
    chk(irq, 1'b1, "R12 unknown opcode keeps irq");
    rd(4'h6, 8'h00, "R12 seq untouched");
    rd(4'h5, 8'h20, "R12 intr untouched");
    rd(4'h3, 8'h55, "R12 command byte stored");

    wr(4'h4, 8'h05);
    wr(4'h3, 8'h42);
    chk(sel_req, 1'b1, "R9 select strobe");
    chk(sel_id == 3'd5, 1'b1, "R9 select id");
    chk(sel_stop, 1'b0, "R9 select no stop");
    @(negedge clk);
    chk(sel_req, 1'b0, "R9 strobe one cycle");
    ok_evt();
    chk(irq, 1'b1, "R10 ok raises irq");
    rd(4'h6, 8'h04, "R10 ok seq");
    rd(4'h4, 8'h90, "R10 ok status");
    rd(4'h5, 8'h18, "R10 ok intr");

    wr(4'h3, 8'h43);
    chk(sel_stop, 1'b1, "R9 select with stop");
    ok_evt();
    rd(4'h4, 8'h92, "R10 ok status with stop");

    wr(4'h4, 8'h03);
    wr(4'h3, 8'h42);
    chk(sel_id == 3'd3, 1'b1, "R9 select id update");
    absent_evt();
    rd(4'h4, 8'h80, "R10 absent status");
    rd(4'h6, 8'h00, "R10 absent seq");
    rd(4'h5, 8'h20, "R10 absent intr");
    chk(irq, 1'b0, "R3 irq low after absent read");

    wr(4'h0, 8'h34);
    wr(4'h1, 8'h12);
    wr(4'h3, 8'h00);
    rd(4'h0, 8'h00, "R11 no reload without bit7");
    wr(4'h3, 8'h80);
    rd(4'h0, 8'h34, "R11 reload tc low");
    rd(4'h1, 8'h12, "R11 reload tc mid");

    wr(4'hC, 8'h77);
    chk(wr_err, 1'b1, "R13 invalid write flagged");
    @(negedge clk);
    chk(wr_err, 1'b0, "R13 flag one cycle");
    rd(4'hC, 8'h00, "R13 invalid write ignored");

    wr(4'h3, 8'h11);
    wr(4'h3, 8'h02);
    chk(irq, 1'b0, "R5 chip reset lowers irq");
    rd(4'h8, 8'h07, "R5 cfg1 restored");
    rd(4'hE, 8'h04, "R5 tc high restored");
    rd(4'h5, 8'h00, "R5 intr cleared");
    rd(4'h0, 8'h00, "R5 tc low cleared");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule